// File: doc/BRIEF.md
# Strided Gather/Scatter Address Sequencer

This block turns a compact vector layout description into the stream of byte addresses a memory port must visit to gather (or scatter) that vector. A layout consists of a base byte address, a signed stride, a group length and a signed skip. Stride, group length and skip are all counted in elements. Within a group, each address is one stride further than the last. When a group ends, the next address also moves by the skip. A per-stream precision bit selects 4-byte or 8-byte elements, and every element offset is scaled into bytes by that size.

A configuration is applied by pulsing `start` while the sequencer is idle. The number of addresses to emit comes from its own length input and is independent of the group length. Addresses leave on a valid/ready stream, one per cycle while the consumer is ready. The address and last flag stay frozen for as long as `out_valid` is high and `out_ready` is low. `out_last` marks the final address of the run. A group length of zero is reported on `cfg_err` and produces no addresses. A unit-layout input replaces the layout with stride 1, group length 1 and skip 0.

Top module: `stride_addr_gen`

## Requirements
- R1: After reset, `out_valid`, `busy` and `cfg_err` are 0.
- R2: A `start` pulse while `busy` is 0 loads the configuration, and the first address, equal to `base`, appears on `out_data` in the cycle after the pulse. A `start` pulse while `busy` is 1 is ignored and leaves the running sequence unchanged.
- R3: Address number k (counting from 0) equals base + (k*stride + floor(k/count)*skip) * esize, taken modulo 2^ADDR_W. Consecutive addresses inside a group differ by stride*esize.
- R4: After every `count` emitted addresses, the step to the next address includes skip elements on top of the stride step.
- R5: esize is 4 bytes when `dbl` = 0 and 8 bytes when `dbl` = 1.
- R6: Stride and skip are two's complement signed values. Negative values move addresses downward, and all address arithmetic wraps modulo 2^ADDR_W.
- R7: Exactly `len` addresses are emitted. `out_last` is 1 on the final one only. After the final handshake, `out_valid` and `busy` return to 0.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data` and `out_last` hold their values on the next cycle.
- R9: A start accepted with an effective count of 0 sets `cfg_err` to 1 and emits no address. The next accepted start with a nonzero count clears `cfg_err`.
- R10: With `unit_layout` = 1, the stride, count and skip inputs are replaced by 1, 1 and 0.
- R11: A start accepted with `len` = 0 emits no address and does not set `cfg_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Load configuration (taken only when idle) |
| base | input | ADDR_W | First byte address |
| stride | input | FIELD_W | Signed element step within a group |
| count | input | CNT_W | Elements per group |
| skip | input | FIELD_W | Signed extra element step between groups |
| dbl | input | 1 | 1 = 8-byte elements, 0 = 4-byte elements |
| unit_layout | input | 1 | Use stride 1, count 1, skip 0 |
| len | input | LEN_W | Number of addresses to emit |
| busy | output | 1 | Sequence in progress |
| cfg_err | output | 1 | Last accepted start had a zero count |
| out_valid | output | 1 | Address available |
| out_ready | input | 1 | Consumer accepts the address |
| out_data | output | ADDR_W | Byte address |
| out_last | output | 1 | Final address of the run |

## Verification
The bench builds the sequencer with a 12-bit address, 6-bit signed stride and skip, a 3-bit group length and a 5-bit run length. With an address space this small, runs of up to 17 elements starting near the top or the bottom of the space wrap past the boundary in both directions. The bench sweeps every stride from -3 to 3, skips of -2, 0 and 2, group lengths 1, 2, 3 and 7, both precisions and three run lengths. A repeating ready pattern stalls the stream throughout, so the hold rule is exercised at every position in a group, including group ends and the last address.

// File: rtl/sag_pkg.sv
package sag_pkg;
  // byte shift for one element: 4-byte or 8-byte
  function automatic int unsigned elem_shift(input logic dbl);
    return dbl ? 3 : 2;
  endfunction
endpackage

// File: rtl/sag_group_ctr.sv
module sag_group_ctr #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             adv,
  input  logic [CNT_W-1:0] limit,
  output logic             at_end
);
  logic [CNT_W-1:0] idx;

  assign at_end = (idx == limit - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)    idx <= '0;
    else if (load) idx <= '0;
    else if (adv)  idx <= at_end ? '0 : idx + CNT_W'(1);
  end
endmodule

// File: rtl/sag_len_ctr.sv
module sag_len_ctr #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] init,
  input  logic             dec,
  output logic             is_last
);
  logic [LEN_W-1:0] rem;

  assign is_last = (rem == LEN_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)    rem <= '0;
    else if (load) rem <= init;
    else if (dec)  rem <= rem - LEN_W'(1);
  end
endmodule

// File: rtl/sag_step.sv
module sag_step #(
  parameter int ADDR_W  = 32,
  parameter int FIELD_W = 16
) (
  input  logic signed [FIELD_W-1:0] stride,
  input  logic signed [FIELD_W-1:0] skip,
  input  logic                      group_end,
  input  logic                      dbl,
  output logic        [ADDR_W-1:0]  step_bytes
);
  localparam int EXT_W = ADDR_W - FIELD_W - 1;

  logic signed [FIELD_W:0] step_el;
  logic        [ADDR_W-1:0] step_ext;

  always_comb begin
    step_el = {stride[FIELD_W-1], stride};
    if (group_end) step_el = step_el + {skip[FIELD_W-1], skip};
    step_ext = {{EXT_W{step_el[FIELD_W]}}, step_el};
    step_bytes = step_ext << sag_pkg::elem_shift(dbl);
  end
endmodule

// File: rtl/stride_addr_gen.sv
module stride_addr_gen #(
  parameter int ADDR_W  = 32,
  parameter int FIELD_W = 16,
  parameter int CNT_W   = 16,
  parameter int LEN_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [ADDR_W-1:0]  base,
  input  logic [FIELD_W-1:0] stride,
  input  logic [CNT_W-1:0]   count,
  input  logic [FIELD_W-1:0] skip,
  input  logic               dbl,
  input  logic               unit_layout,
  input  logic [LEN_W-1:0]   len,
  output logic               busy,
  output logic               cfg_err,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [ADDR_W-1:0]  out_data,
  output logic               out_last
);
  logic [FIELD_W-1:0] eff_stride, eff_skip, r_stride, r_skip;
  logic [CNT_W-1:0]   eff_count, r_count;
  logic               r_dbl;
  logic [ADDR_W-1:0]  cur_addr, step_bytes;
  logic               accept, fire, group_end, is_last;

  assign eff_stride = unit_layout ? FIELD_W'(1) : stride;
  assign eff_skip   = unit_layout ? '0 : skip;
  assign eff_count  = unit_layout ? CNT_W'(1) : count;

  assign accept    = start && !busy;
  assign fire      = out_valid && out_ready;
  assign out_valid = busy;
  assign out_data  = cur_addr;
  assign out_last  = busy && is_last;

  sag_group_ctr #(.CNT_W(CNT_W)) u_grp (
    .clk(clk), .rst_n(rst_n), .load(accept), .adv(fire),
    .limit(r_count), .at_end(group_end)
  );

  sag_len_ctr #(.LEN_W(LEN_W)) u_len (
    .clk(clk), .rst_n(rst_n), .load(accept), .init(len),
    .dec(fire), .is_last(is_last)
  );

  sag_step #(.ADDR_W(ADDR_W), .FIELD_W(FIELD_W)) u_step (
    .stride(r_stride), .skip(r_skip), .group_end(group_end),
    .dbl(r_dbl), .step_bytes(step_bytes)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cfg_err  <= 1'b0;
      cur_addr <= '0;
      r_stride <= '0;
      r_skip   <= '0;
      r_count  <= CNT_W'(1);
      r_dbl    <= 1'b0;
    end else if (accept) begin
      cfg_err  <= (eff_count == '0);
      busy     <= (eff_count != '0) && (len != '0);
      cur_addr <= base;
      r_stride <= eff_stride;
      r_skip   <= eff_skip;
      r_count  <= eff_count;
      r_dbl    <= dbl;
    end else if (fire) begin
      if (is_last) busy <= 1'b0;
      else         cur_addr <= cur_addr + step_bytes;
    end
  end
endmodule

// File: rtl/sag_chk.sv
module sag_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              out_valid,
  input logic              out_ready,
  input logic [ADDR_W-1:0] out_data,
  input logic              out_last,
  input logic              cfg_err
);
  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));
  // R7
  last_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |=> !out_valid);
  // R7
  not_last_continues_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !out_last |=> out_valid);
  // R9
  err_no_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !out_valid);
  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |=> !out_valid && !cfg_err);
endmodule

bind stride_addr_gen sag_chk #(.ADDR_W(ADDR_W)) u_sag_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .out_last(out_last), .cfg_err(cfg_err)
);

// File: tb/stride_addr_gen_bench.sv
module stride_addr_gen_bench;
  localparam int AW = 12, FW = 6, CW = 3, LW = 5;

  logic clk = 0, rst_n = 0, start = 0, dbl = 0, unit_layout = 0, out_ready = 0;
  logic [AW-1:0] base = '0;
  logic [FW-1:0] stride = '0, skip = '0;
  logic [CW-1:0] count = '0;
  logic [LW-1:0] len = '0;
  logic busy, cfg_err, out_valid, out_last;
  logic [AW-1:0] out_data;

  int checks = 0, fails = 0, cyc = 0;

  always #10 clk = ~clk;

  stride_addr_gen #(.ADDR_W(AW), .FIELD_W(FW), .CNT_W(CW), .LEN_W(LW)) u_stride_addr_gen (
    .clk(clk), .rst_n(rst_n), .start(start), .base(base), .stride(stride),
    .count(count), .skip(skip), .dbl(dbl), .unit_layout(unit_layout), .len(len),
    .busy(busy), .cfg_err(cfg_err), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_last(out_last)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_addr(int b, int s, int c, int k2, int d, int k);
    int e = d ? 8 : 4;
    return (b + (k * s + (k / c) * k2) * e) & ((1 << AW) - 1);
  endfunction

  // run one stream; extra_start pulses start while busy (must be ignored)
  task automatic run(input int b, input int s, input int c, input int k2,
                     input int d, input int n, input bit unit, input bit extra_start);
    int es = unit ? 1 : s;
    int ec = unit ? 1 : c;
    int ek = unit ? 0 : k2;
    int k = 0;
    bit stalled = 0;
    logic [AW-1:0] held = '0;
    logic held_last = 0;
    @(negedge clk);
    base = AW'(b); stride = FW'(s); count = CW'(c); skip = FW'(k2);
    dbl = d[0]; unit_layout = unit; len = LW'(n); start = 1;
    @(negedge clk);
    start = 0;
    // R2 first address appears one cycle after start
    chk(out_valid === 1'b1 && out_data === AW'(b), "R2", int'(out_data), b);
    while (k < n) begin
      cyc++;
      if (extra_start && k == 1) begin
        base = ~base; start = 1;
      end else start = 0;
      if (stalled) begin
        // R8 held values under back-pressure
        chk(out_valid === 1'b1 && out_data === held && out_last === held_last,
            "R8", int'(out_data), int'(held));
      end
      // R3 R4 R5 R6 address formula, R10 unit layout
      chk(out_valid === 1'b1 && out_data === AW'(exp_addr(b, es, ec, ek, d, k)),
          unit ? "R10" : "R3/R4/R5/R6", int'(out_data), exp_addr(b, es, ec, ek, d, k));
      // R7 last flag
      chk(out_last === (k == n - 1), "R7", int'(out_last), int'(k == n - 1));
      out_ready = ((cyc * 5 + 3) % 7) != 0;
      stalled = !out_ready;
      held = out_data; held_last = out_last;
      if (out_ready) k++;
      @(negedge clk);
      if (cyc > 150000) break;
    end
    start = 0;
    // R7 idle after final handshake
    chk(out_valid === 1'b0 && busy === 1'b0, "R7", int'(out_valid), 0);
    out_ready = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(out_valid === 1'b0 && busy === 1'b0 && cfg_err === 1'b0, "R1", int'(out_valid), 0);
    rst_n = 1;

    for (int s = -3; s <= 3; s++)
      for (int ki = 0; ki < 3; ki++)
        for (int ci = 0; ci < 4; ci++)
          for (int d = 0; d < 2; d++)
            for (int ni = 0; ni < 3; ni++) begin
              int kv = (ki - 1) * 2;
              int cv = (ci == 3) ? 7 : ci + 1;
              int nv = (ni == 0) ? 1 : (ni == 1) ? 5 : 17;
              int bv = (s >= 0) ? 12'hFE0 : 12'h010;
              run(bv, s, cv, kv, d, nv, 1'b0, 1'b0);
            end

    // R10 unit layout overrides fields
    run(12'h100, -3, 0, 2, 1, 9, 1'b1, 1'b0);
    run(12'hFF8, 2, 5, -1, 0, 6, 1'b1, 1'b0);
    // R2 start while busy ignored
    run(12'h040, 2, 3, 1, 0, 10, 1'b0, 1'b1);

    // R9 zero count flags error, no output
    @(negedge clk);
    count = '0; len = LW'(4); unit_layout = 0; start = 1;
    @(negedge clk);
    start = 0;
    chk(cfg_err === 1'b1 && out_valid === 1'b0, "R9", int'(cfg_err), 1);
    out_ready = 1;
    repeat (3) @(negedge clk);
    chk(cfg_err === 1'b1 && out_valid === 1'b0 && busy === 1'b0, "R9", int'(out_valid), 0);
    out_ready = 0;
    run(12'h200, 1, 2, 0, 1, 3, 1'b0, 1'b0);
    chk(cfg_err === 1'b0, "R9", int'(cfg_err), 0);

    // R11 zero length: nothing emitted, no error
    @(negedge clk);
    count = CW'(2); len = '0; start = 1;
    @(negedge clk);
    start = 0;
    chk(out_valid === 1'b0 && busy === 1'b0 && cfg_err === 1'b0, "R11", int'(out_valid), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule